// File: doc/BRIEF.md
# ECC Error Log and Interrupt Unit

This unit sits beside a 64-bit single-error-correct, double-error-detect checker and keeps a record of the errors it reports, so that an interrupt handler can find and scrub the failing word. Every cycle in which the checker flags an event, the unit receives the error kind (single or double), the 8-bit syndrome, the byte address of the failing word and the 3-bit identifier of the bus master that issued the access. The correction of the data itself happens elsewhere, and logging runs in parallel with it.

Two capture slots each hold a log word and an address word. Each slot is tied to one bit of an interrupt status register. A slot is free while its status bit is 0, and the lowest free slot takes the next event. When both slots are taken, the event is not recorded but a sticky "dropped" flag is raised. The interrupt line is high while any status bit is set. Software reads and clears everything through a small word-addressed register port: offset 0 is status, offsets 1 and 2 are slot 0's log and address, offsets 3 and 4 are slot 1's log and address, and every other offset reads as zero.

Top module: `ecc_errlog_top`

## Requirements
- R1: After reset, status, both log words and both address words read 0, and the interrupt output is low.
- R2: An event with both slots free loads slot 0 and sets status bit 0. Its log word holds the syndrome in bits [7:0], the master ID in bits [18:16], a 0 in bit 8 for a single-bit error, and 0 in all other bits.
- R3: A slot's address word holds event address bits [31:2] in place, and reads bits [1:0] as 0.
- R4: An event that arrives while slot 0 is occupied and slot 1 is free loads slot 1 and sets status bit 1, leaving slot 0's words unchanged.
- R5: An event that arrives while both slots are occupied changes no log or address word and sets the dropped flag, status bit 2.
- R6: The interrupt output is high exactly when any of status bits [2:0] is 1.
- R7: Writing offset 0 clears each status bit whose write-data bit is 1 and leaves the others; such a write does not alter any log or address word. Unmapped offsets read 0.
- R8: Log and address words keep their contents after their status bit is cleared; a write of any data to a log or address offset sets that word to 0.
- R9: When an event and a status clear target the same slot (or the dropped flag) in the same cycle, the event wins: the bit stays 1 and the slot takes the new event.
- R10: With slot 1 occupied and slot 0 free, the next event goes to slot 0.
- R11: A double-bit error takes the same slot as a single-bit error would and sets bit 8 of its log word to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid_i | input | 1 | Checker reports an error this cycle |
| evt_double_i | input | 1 | 1 = uncorrectable double-bit error, 0 = single-bit |
| evt_syndrome_i | input | 8 | Syndrome of the failing word |
| evt_master_i | input | 3 | ID of the bus master of the access |
| evt_addr_i | input | 32 | Byte address of the failing word |
| reg_addr_i | input | 3 | Word offset for register read and write |
| reg_wen_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The assertions assume the checker raises evt_valid_i for exactly one cycle per error and that its fields are valid in that cycle; they also assume a register write lasts one cycle and is not repeated. The stimulus drives every event and every write on the falling edge for a single cycle, reads only between events, and creates the same-cycle collisions of R9 on purpose by asserting an event and a status write on the same falling edge.

// File: rtl/ecc_errlog_pkg.sv
package ecc_errlog_pkg;

    localparam int SYN_W   = 8;
    localparam int MID_W   = 3;
    localparam int ADDR_W  = 32;
    localparam int WORD_W  = 32;
    localparam int DBL_BIT = 8;
    localparam int MID_LSB = 16;

    typedef struct packed {
        logic             dbl;
        logic [SYN_W-1:0] syn;
        logic [MID_W-1:0] mid;
    } log_t;

    typedef logic [ADDR_W-3:0] waddr_t;

    function automatic logic [WORD_W-1:0] pack_log(input log_t e);
        logic [WORD_W-1:0] w;
        w                            = '0;
        w[SYN_W-1:0]                 = e.syn;
        w[DBL_BIT]                   = e.dbl;
        w[MID_LSB +: MID_W]          = e.mid;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_addr(input waddr_t a);
        return {a, 2'b00};
    endfunction

endpackage

// File: rtl/ecc_log_slot.sv
module ecc_log_slot
    import ecc_errlog_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load_i,
    input  logic   clr_log_i,
    input  logic   clr_addr_i,
    input  log_t   log_i,
    input  waddr_t addr_i,
    output log_t   log_o,
    output waddr_t addr_o
);

    typedef struct packed {
        log_t   log;
        waddr_t addr;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (clr_log_i)  slot_d.log  = '0;
        if (clr_addr_i) slot_d.addr = '0;
        if (load_i) begin
            slot_d.log  = log_i;
            slot_d.addr = addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign log_o  = slot_q.log;
    assign addr_o = slot_q.addr;

    p_hold_log_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !clr_log_i) |=> $stable(log_o));

    p_hold_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !clr_addr_i) |=> $stable(addr_o));

    p_load_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (log_o == $past(log_i)) && (addr_o == $past(addr_i)));

endmodule

// File: rtl/ecc_log_alloc.sv
module ecc_log_alloc #(
    parameter int NUM_SLOTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_valid_i,
    input  logic [NUM_SLOTS-1:0] clr_slot_i,
    input  logic                 clr_drop_i,
    output logic [NUM_SLOTS-1:0] load_o,
    output logic [NUM_SLOTS-1:0] busy_o,
    output logic                 drop_o
);

    typedef struct packed {
        logic                 drop;
        logic [NUM_SLOTS-1:0] busy;
    } st_t;

    st_t                  st_d, st_q;
    logic [NUM_SLOTS-1:0] free;
    logic [NUM_SLOTS-1:0] load;
    logic                 placed;

    always_comb begin
        free   = ~st_q.busy | clr_slot_i;
        load   = '0;
        placed = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (evt_valid_i && !placed && free[i]) begin
                load[i] = 1'b1;
                placed  = 1'b1;
            end
        end
        st_d.busy = (st_q.busy & ~clr_slot_i) | load;
        st_d.drop = (st_q.drop & ~clr_drop_i) | (evt_valid_i & ~placed);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_o = load;
    assign busy_o = st_q.busy;
    assign drop_o = st_q.drop;

    p_one_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_o));

    p_no_overwrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o & busy_o & ~clr_slot_i) == '0);

    p_drop_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_i && (&(busy_o & ~clr_slot_i))) |=> drop_o);

    p_drop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_i && load_o == '0) |=> drop_o);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chk
        p_evt_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            load_o[g] |=> busy_o[g]);
        p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_slot_i[g] && !load_o[g]) |=> !busy_o[g]);
    end

endmodule

// File: rtl/ecc_errlog_top.sv
module ecc_errlog_top
    import ecc_errlog_pkg::*;
#(
    parameter int NUM_SLOTS = 2,
    localparam int NUM_REGS = 2 * NUM_SLOTS + 1,
    localparam int RA_W     = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid_i,
    input  logic              evt_double_i,
    input  logic [SYN_W-1:0]  evt_syndrome_i,
    input  logic [MID_W-1:0]  evt_master_i,
    input  logic [ADDR_W-1:0] evt_addr_i,
    input  logic [RA_W-1:0]   reg_addr_i,
    input  logic              reg_wen_i,
    input  logic [WORD_W-1:0] reg_wdata_i,
    output logic [WORD_W-1:0] reg_rdata_o,
    output logic              irq_o
);

    logic [NUM_SLOTS-1:0] load, busy, clr_slot, clr_log, clr_addr;
    logic                 drop, clr_drop, wr_status;
    log_t                 evt_log;
    waddr_t               evt_waddr;
    log_t                 slot_log  [NUM_SLOTS];
    waddr_t               slot_addr [NUM_SLOTS];
    int unsigned          ra;

    assign ra        = int'(reg_addr_i);
    assign evt_log   = '{dbl: evt_double_i, syn: evt_syndrome_i, mid: evt_master_i};
    assign evt_waddr = evt_addr_i[ADDR_W-1:2];
    assign wr_status = reg_wen_i && (ra == 0);
    assign clr_slot  = wr_status ? reg_wdata_i[NUM_SLOTS-1:0] : '0;
    assign clr_drop  = wr_status & reg_wdata_i[NUM_SLOTS];

    ecc_log_alloc #(.NUM_SLOTS(NUM_SLOTS)) alloc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_valid_i(evt_valid_i),
        .clr_slot_i (clr_slot),
        .clr_drop_i (clr_drop),
        .load_o     (load),
        .busy_o     (busy),
        .drop_o     (drop)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign clr_log[g]  = reg_wen_i && (ra == 2 * g + 1);
        assign clr_addr[g] = reg_wen_i && (ra == 2 * g + 2);

        ecc_log_slot slot_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (load[g]),
            .clr_log_i (clr_log[g]),
            .clr_addr_i(clr_addr[g]),
            .log_i     (evt_log),
            .addr_i    (evt_waddr),
            .log_o     (slot_log[g]),
            .addr_o    (slot_addr[g])
        );
    end

    always_comb begin
        reg_rdata_o = '0;
        if (ra == 0) reg_rdata_o[NUM_SLOTS:0] = {drop, busy};
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (ra == 2 * i + 1) reg_rdata_o = pack_log(slot_log[i]);
            if (ra == 2 * i + 2) reg_rdata_o = pack_addr(slot_addr[i]);
        end
    end

    assign irq_o = drop | (|busy);

    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(evt_valid_i));

    p_irq_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_i && !clr_drop) |=> irq_o);

endmodule

// File: tb/ecc_errlog_tb_top.sv
module ecc_errlog_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0, evt_double = 1'b0;
    logic [7:0]  evt_syn = '0;
    logic [2:0]  evt_mid = '0;
    logic [31:0] evt_addr = '0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ecc_errlog_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .evt_valid_i(evt_valid), .evt_double_i(evt_double),
        .evt_syndrome_i(evt_syn), .evt_master_i(evt_mid), .evt_addr_i(evt_addr),
        .reg_addr_i(reg_addr), .reg_wen_i(reg_wen), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, $sformatf("offset %0d", a), d, exp);
    endtask

    task automatic irq_check(input string req, input logic exp);
        @(negedge clk);
        #1 check(req, "irq", {31'b0, irq}, {31'b0, exp});
    endtask

    // one cycle of optional event and optional register write on the same edge
    task automatic cycle(input logic ev, input logic dbl, input logic [7:0] syn,
                         input logic [2:0] mid, input logic [31:0] addr,
                         input logic wen, input logic [2:0] wa, input logic [31:0] wd);
        @(negedge clk);
        evt_valid = ev; evt_double = dbl; evt_syn = syn; evt_mid = mid; evt_addr = addr;
        reg_wen = wen; reg_addr = wa; reg_wdata = wd;
        @(negedge clk);
        evt_valid = 1'b0; reg_wen = 1'b0;
    endtask

    task automatic event_in(input logic dbl, input logic [7:0] syn,
                            input logic [2:0] mid, input logic [31:0] addr);
        cycle(1'b1, dbl, syn, mid, addr, 1'b0, 3'd0, 32'd0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cycle(1'b0, 1'b0, 8'd0, 3'd0, 32'd0, 1'b1, a, d);
    endtask

    task automatic t_reset;
        rd_check("R1", 3'd0, 32'h0);
        rd_check("R1", 3'd1, 32'h0);
        rd_check("R1", 3'd2, 32'h0);
        rd_check("R1", 3'd3, 32'h0);
        rd_check("R1", 3'd4, 32'h0);
        irq_check("R1", 1'b0);
    endtask

    task automatic t_first;
        event_in(1'b0, 8'hA5, 3'd5, 32'h1234_567B);
        rd_check("R2", 3'd0, 32'h1);
        rd_check("R2", 3'd1, 32'h0005_00A5);
        rd_check("R3", 3'd2, 32'h1234_5678);
        irq_check("R6", 1'b1);
    endtask

    task automatic t_second_double;
        event_in(1'b1, 8'h3C, 3'd2, 32'h8000_0006);
        rd_check("R4", 3'd0, 32'h3);
        rd_check("R11", 3'd3, 32'h0002_013C);
        rd_check("R3", 3'd4, 32'h8000_0004);
        rd_check("R4", 3'd1, 32'h0005_00A5);
    endtask

    task automatic t_full_drop;
        event_in(1'b0, 8'hFF, 3'd7, 32'hFFFF_FFFF);
        rd_check("R5", 3'd0, 32'h7);
        rd_check("R5", 3'd1, 32'h0005_00A5);
        rd_check("R5", 3'd2, 32'h1234_5678);
        rd_check("R5", 3'd3, 32'h0002_013C);
        rd_check("R5", 3'd4, 32'h8000_0004);
    endtask

    task automatic t_w1c;
        wr(3'd0, 32'h1);
        rd_check("R7", 3'd0, 32'h6);
        rd_check("R7", 3'd1, 32'h0005_00A5);
        wr(3'd0, 32'h0);
        rd_check("R7", 3'd0, 32'h6);
        rd_check("R7", 3'd6, 32'h0);
        wr(3'd0, 32'h2);
        rd_check("R7", 3'd0, 32'h4);
        irq_check("R6", 1'b1);
        wr(3'd0, 32'h4);
        rd_check("R7", 3'd0, 32'h0);
        irq_check("R6", 1'b0);
    endtask

    task automatic t_retain_clear;
        rd_check("R8", 3'd1, 32'h0005_00A5);
        rd_check("R8", 3'd4, 32'h8000_0004);
        wr(3'd1, 32'hDEAD_BEEF);
        rd_check("R8", 3'd1, 32'h0);
        rd_check("R8", 3'd2, 32'h1234_5678);
        wr(3'd2, 32'h0);
        rd_check("R8", 3'd2, 32'h0);
        rd_check("R8", 3'd3, 32'h0002_013C);
    endtask

    task automatic t_realloc;
        event_in(1'b0, 8'h01, 3'd0, 32'h10);
        event_in(1'b0, 8'h02, 3'd1, 32'h20);
        rd_check("R10", 3'd0, 32'h3);
        wr(3'd0, 32'h1);
        event_in(1'b0, 8'h11, 3'd1, 32'h40);
        rd_check("R10", 3'd0, 32'h3);
        rd_check("R10", 3'd1, 32'h0001_0011);
        rd_check("R10", 3'd2, 32'h0000_0040);
        rd_check("R10", 3'd3, 32'h0001_0002);
    endtask

    task automatic t_collide;
        cycle(1'b1, 1'b1, 8'h22, 3'd3, 32'h0000_0100, 1'b1, 3'd0, 32'h1);
        rd_check("R9", 3'd0, 32'h3);
        rd_check("R9", 3'd1, 32'h0003_0122);
        rd_check("R9", 3'd2, 32'h0000_0100);
        cycle(1'b1, 1'b0, 8'h33, 3'd4, 32'h0000_0200, 1'b1, 3'd0, 32'h4);
        rd_check("R9", 3'd0, 32'h7);
        rd_check("R9", 3'd1, 32'h0003_0122);
        wr(3'd0, 32'h7);
        rd_check("R7", 3'd0, 32'h0);
        irq_check("R6", 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_first();
        t_second_double();
        t_full_drop();
        t_w1c();
        t_retain_clear();
        t_realloc();
        t_collide();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule